// File: doc/BRIEF.md
# Audio Codec Mixer Register Bank

This block is a small bank of 16-bit control registers for a stereo audio codec. A host reaches it through a plain synchronous port. An even 7-bit index is presented with a write strobe and write data, or with a read strobe. Read data appears one cycle after the read strobe. The bank holds a fixed capability/identity word, a stereo master volume with its mute controls, a serial configuration word, and a vendor configuration word. The vendor word has two controls. One enables independent muting of the right channel. The other widens the reach of the master volume to the center and subwoofer (LFE) paths.

The master volume fields are decoded into sideband outputs that the analog attenuators use directly. Each channel gets an attenuation step count, where one step is 1.5 dB and the range is 0 to 31 steps (0 dB to 46.5 dB). Each channel also gets a mute flag. Two enable flags tell the center and LFE attenuators to follow the master setting. A write of any value to the identity index acts as a soft reset. It returns every register to its default except the serial configuration word.

Top module: `codec_regbank`

## Requirements
- R1: After the reset input is released, index 02h reads 8000h and indices 74h and 76h read 0000h. Both attenuation outputs are 0, both mute outputs are 1, and the center and LFE enables are 0.
- R2: A read of index 00h returns 0090h, with the capability code in bits 9:0 and zeros in bits 15:10. Writes never change this value.
- R3: A write of any data to index 00h restores index 02h to 8000h and index 76h to 0000h. Index 74h keeps its contents.
- R4: At index 02h, bit 15 is the main mute, bits 13:8 are the left volume and bits 5:0 are the right volume. Bits 14 and 6 read 0. Each attenuation output equals the low five bits of its channel's stored volume, in 1.5 dB steps.
- R5: When bit 13 (or bit 5) of a write to index 02h is 1, the five bits below it are stored as ones. Readback shows them as ones, and the channel's attenuation output becomes 31.
- R6: While the split-mute enable (bit 4 of index 76h) is 0, a 1 written to bit 7 of index 02h is discarded. That bit reads 0, and setting the split-mute enable later does not bring it back. Bit 15 mutes both channels.
- R7: While the split-mute enable is 1, bit 15 mutes only the left channel. Bit 7 mutes only the right channel and reads back as written.
- R8: Bit 2 of index 76h is the routing control. At 1 both the center and LFE enables are 1, and at 0 both are 0. Only bits 4 and 2 of index 76h store data; all other bits read 0.
- R9: Index 74h stores and returns all 16 written bits.
- R10: Writes to unimplemented indices or to odd addresses change nothing, and such a write to address 01h does not act as a soft reset. Reads of unimplemented indices or odd addresses return 0000h.
- R11: Read data is valid in the cycle after the read strobe and holds until the next read. A read and a write to the same index in one cycle return the value from before the write. The sideband outputs change only in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 7 | Register index for reads and writes |
| wdata | input | 16 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 16 | Read data, registered |
| left_atten | output | 5 | Left attenuation in 1.5 dB steps |
| right_atten | output | 5 | Right attenuation in 1.5 dB steps |
| left_mute | output | 1 | Left channel muted |
| right_mute | output | 1 | Right channel muted |
| center_en | output | 1 | Center attenuator follows master volume |
| lfe_en | output | 1 | LFE attenuator follows master volume |

## Verification
The volume register is written with plain mid-range values, with all ones, and with a range bit set above low data. These patterns show whether the low five bits pass through unchanged or are forced to saturate. Bit 7 is written with the split-mute enable both clear and set, and then with the main mute, so the checks can tell a joint mute from an independent right mute. They also show whether a bit 7 written while the feature was off is dropped rather than held. A soft reset follows a write of a marker pattern to the serial word, which shows whether that word alone is kept. Odd addresses, unimplemented indices and a read in the same cycle as a write probe the decode and the read timing.

// File: rtl/codec_rb_pkg.sv
package codec_rb_pkg;

   // register indices (even, 7-bit)
   localparam logic [6:0] IDX_IDENT  = 7'h00;
   localparam logic [6:0] IDX_MASTER = 7'h02;
   localparam logic [6:0] IDX_SERIAL = 7'h74;
   localparam logic [6:0] IDX_VENDOR = 7'h76;

   // bit positions inside the vendor configuration word
   localparam int CFG_SPLIT_BIT = 4;
   localparam int CFG_ROUTE_BIT = 2;

   // sideband bundle handed to the attenuators
   typedef struct packed {
      logic mute_l;
      logic mute_r;
      logic aux_on;
   } side_flags_t;

endpackage

// File: rtl/cr_vol_chan.sv
module cr_vol_chan #(
   parameter int VOL_W  = 6,
   parameter bit SAT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             wr,
   input  logic [VOL_W-1:0] wval,
   output logic [VOL_W-1:0] vol_q
);
   localparam int LOW_W = VOL_W - 1;

   logic [VOL_W-1:0] wfix;

   generate
      if (SAT_EN) begin : g_sat
         // range bit set: low field saturates to full attenuation
         always_comb wfix = wval[VOL_W-1] ? {1'b1, {LOW_W{1'b1}}} : wval;
      end else begin : g_raw
         always_comb wfix = wval;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        vol_q <= '0;
      else if (soft_rst) vol_q <= '0;
      else if (wr)       vol_q <= wfix;
   end
endmodule

// File: rtl/cr_sideband.sv
module cr_sideband import codec_rb_pkg::*; #(
   parameter int VOL_W = 6,
   localparam int ATT_W = VOL_W - 1
) (
   input  logic [VOL_W-1:0] lvol,
   input  logic [VOL_W-1:0] rvol,
   input  logic             mute_main,
   input  logic             mute_right,
   input  logic             split,
   input  logic             route,
   output logic [ATT_W-1:0] left_atten,
   output logic [ATT_W-1:0] right_atten,
   output logic             left_mute,
   output logic             right_mute,
   output logic             center_en,
   output logic             lfe_en
);
   side_flags_t fl;

   always_comb begin
      fl.mute_l = mute_main;
      fl.mute_r = split ? mute_right : mute_main;
      fl.aux_on = route;
   end

   assign left_atten  = lvol[ATT_W-1:0];
   assign right_atten = rvol[ATT_W-1:0];
   assign left_mute   = fl.mute_l;
   assign right_mute  = fl.mute_r;
   assign center_en   = fl.aux_on;
   assign lfe_en      = fl.aux_on;
endmodule

// File: rtl/cr_read_mux.sv
module cr_read_mux import codec_rb_pkg::*; #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 7,
   parameter int VOL_W  = 6
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] cap_word,
   input  logic              mute_main,
   input  logic              mute_right,
   input  logic              split,
   input  logic              route,
   input  logic [VOL_W-1:0]  lvol,
   input  logic [VOL_W-1:0]  rvol,
   input  logic [DATA_W-1:0] serial,
   output logic [DATA_W-1:0] word
);
   localparam int HALF = DATA_W / 2;

   logic [DATA_W-1:0] mst_word, ven_word;

   always_comb begin
      mst_word                 = '0;
      mst_word[DATA_W-1]       = mute_main;
      mst_word[HALF +: VOL_W]  = lvol;
      mst_word[HALF-1]         = mute_right & split;
      mst_word[VOL_W-1:0]      = rvol;
      ven_word                 = '0;
      ven_word[CFG_SPLIT_BIT]  = split;
      ven_word[CFG_ROUTE_BIT]  = route;
   end

   always_comb begin
      if (addr == ADDR_W'(IDX_IDENT))       word = cap_word;
      else if (addr == ADDR_W'(IDX_MASTER)) word = mst_word;
      else if (addr == ADDR_W'(IDX_SERIAL)) word = serial;
      else if (addr == ADDR_W'(IDX_VENDOR)) word = ven_word;
      else                                  word = '0;
   end
endmodule

// File: rtl/codec_regbank.sv
module codec_regbank import codec_rb_pkg::*; #(
   parameter int         DATA_W   = 16,
   parameter int         ADDR_W   = 7,
   parameter int         VOL_W    = 6,
   parameter logic [9:0] CAP_ID   = 10'h090,
   parameter logic [4:0] ENH_CODE = 5'h00,
   parameter bit         SAT_EN   = 1'b1,
   localparam int        ATT_W    = VOL_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rdata,
   output logic [ATT_W-1:0]  left_atten,
   output logic [ATT_W-1:0]  right_atten,
   output logic              left_mute,
   output logic              right_mute,
   output logic              center_en,
   output logic              lfe_en
);
   localparam int                HALF     = DATA_W / 2;
   localparam logic [DATA_W-1:0] CAP_WORD = DATA_W'({ENH_CODE, CAP_ID});

   initial begin
      assert (DATA_W == 16) else $error("register layout needs DATA_W == 16");
      assert (ADDR_W >= 7)  else $error("ADDR_W must cover 7-bit indices");
      assert (VOL_W == 6)   else $error("volume layout needs VOL_W == 6");
   end

   logic wr_id, wr_mst, wr_ser, wr_ven;
   assign wr_id  = wr_en & (addr == ADDR_W'(IDX_IDENT));
   assign wr_mst = wr_en & (addr == ADDR_W'(IDX_MASTER));
   assign wr_ser = wr_en & (addr == ADDR_W'(IDX_SERIAL));
   assign wr_ven = wr_en & (addr == ADDR_W'(IDX_VENDOR));

   // channel 0 = right (low half), channel 1 = left (high half)
   logic [VOL_W-1:0] vol_q [2];

   generate
      for (genvar c = 0; c < 2; c++) begin : g_ch
         cr_vol_chan #(.VOL_W(VOL_W), .SAT_EN(SAT_EN)) u_vol (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (wr_id),
            .wr       (wr_mst),
            .wval     (wdata[c*HALF +: VOL_W]),
            .vol_q    (vol_q[c])
         );
      end
   endgenerate

   logic mute_main_q, mute_right_q, split_q, route_q;
   logic [DATA_W-1:0] serial_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mute_main_q  <= 1'b1;
         mute_right_q <= 1'b0;
         split_q      <= 1'b0;
         route_q      <= 1'b0;
      end else if (wr_id) begin
         mute_main_q  <= 1'b1;
         mute_right_q <= 1'b0;
         split_q      <= 1'b0;
         route_q      <= 1'b0;
      end else begin
         if (wr_mst) begin
            mute_main_q  <= wdata[DATA_W-1];
            mute_right_q <= wdata[HALF-1] & split_q;
         end
         if (wr_ven) begin
            split_q <= wdata[CFG_SPLIT_BIT];
            route_q <= wdata[CFG_ROUTE_BIT];
         end
      end
   end

   // serial word survives the soft reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      serial_q <= '0;
      else if (wr_ser) serial_q <= wdata;
   end

   logic [DATA_W-1:0] rd_word;

   cr_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VOL_W(VOL_W)) u_rmux (
      .addr       (addr),
      .cap_word   (CAP_WORD),
      .mute_main  (mute_main_q),
      .mute_right (mute_right_q),
      .split      (split_q),
      .route      (route_q),
      .lvol       (vol_q[1]),
      .rvol       (vol_q[0]),
      .serial     (serial_q),
      .word       (rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_word;
   end

   cr_sideband #(.VOL_W(VOL_W)) u_side (
      .lvol        (vol_q[1]),
      .rvol        (vol_q[0]),
      .mute_main   (mute_main_q),
      .mute_right  (mute_right_q),
      .split       (split_q),
      .route       (route_q),
      .left_atten  (left_atten),
      .right_atten (right_atten),
      .left_mute   (left_mute),
      .right_mute  (right_mute),
      .center_en   (center_en),
      .lfe_en      (lfe_en)
   );
endmodule

// File: rtl/codec_regbank_chk.sv
module codec_regbank_chk #(
   parameter int                ADDR_W   = 7,
   parameter int                DATA_W   = 16,
   parameter int                ATT_W    = 5,
   parameter logic [DATA_W-1:0] CAP_WORD = 16'h0090
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W-1:0] rdata,
   input logic [ATT_W-1:0]  left_atten,
   input logic [ATT_W-1:0]  right_atten,
   input logic              left_mute,
   input logic              right_mute,
   input logic              center_en,
   input logic              lfe_en,
   input logic              split_q
);
   // R3
   soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == '0) |=> (left_atten == '0 && right_atten == '0 &&
                                 left_mute && right_mute && !center_en && !lfe_en));

   // R2
   ident_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == '0) |=> (rdata == CAP_WORD));

   // R6
   joint_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !split_q |-> (left_mute == right_mute));

   // R10
   odd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr[0]) |=> (rdata == '0));

   // R11
   side_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(left_atten) && $stable(right_atten) && $stable(left_mute) &&
                  $stable(right_mute) && $stable(center_en) && $stable(lfe_en)));

   // R11
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

   // R8
   aux_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      center_en == lfe_en);
endmodule

bind codec_regbank codec_regbank_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ATT_W(ATT_W), .CAP_WORD(CAP_WORD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
   .rdata(rdata), .left_atten(left_atten), .right_atten(right_atten),
   .left_mute(left_mute), .right_mute(right_mute), .center_en(center_en),
   .lfe_en(lfe_en), .split_q(split_q)
);

// File: tb/tb_codec_regbank.sv
module tb_codec_regbank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [15:0] rdata;
   logic [4:0]  left_atten, right_atten;
   logic        left_mute, right_mute, center_en, lfe_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic rd_seen = 1'b0;
   logic [15:0] exp_q[$];
   string       tag_q[$];

   always #4 clk = ~clk;   // 125 MHz

   codec_regbank dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .rd_en(rd_en), .rdata(rdata), .left_atten(left_atten),
      .right_atten(right_atten), .left_mute(left_mute), .right_mute(right_mute),
      .center_en(center_en), .lfe_en(lfe_en)
   );

   // monitor: compares each read result against the scoreboard
   always @(posedge clk) rd_seen <= rd_en;

   always @(negedge clk) begin
      if (rd_seen) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R11 unexpected read data: actual %h expected none", rdata);
         end else begin
            automatic logic [15:0] e = exp_q.pop_front();
            automatic string       t = tag_q.pop_front();
            if (rdata !== e) begin
               errors++;
               $display("FAIL %s read: actual %h expected %h", t, rdata, e);
            end
         end
      end
   end

   task automatic wr(input logic [6:0] a, input logic [15:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, input logic [15:0] e, input string t);
      @(negedge clk);
      exp_q.push_back(e); tag_q.push_back(t);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic rdwr(input logic [6:0] a, input logic [15:0] d,
                       input logic [15:0] e, input string t);
      @(negedge clk);
      exp_q.push_back(e); tag_q.push_back(t);
      addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic side(input logic [4:0] la, input logic [4:0] ra, input logic lm,
                       input logic rm, input logic aux, input string t);
      checks++;
      if (left_atten !== la || right_atten !== ra || left_mute !== lm ||
          right_mute !== rm || center_en !== aux || lfe_en !== aux) begin
         errors++;
         $display("FAIL %s sideband: actual la=%0d ra=%0d lm=%b rm=%b c=%b l=%b expected la=%0d ra=%0d lm=%b rm=%b c=%b l=%b",
                  t, left_atten, right_atten, left_mute, right_mute, center_en, lfe_en,
                  la, ra, lm, rm, aux, aux);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R11 watchdog expired: actual hung expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      side(5'd0, 5'd0, 1'b1, 1'b1, 1'b0, "R1");
      rd(7'h02, 16'h8000, "R1");
      rd(7'h76, 16'h0000, "R1");
      rd(7'h74, 16'h0000, "R1");
      // R2 identity word
      rd(7'h00, 16'h0090, "R2");

      // R4 plain volume values
      wr(7'h02, 16'h0A05);
      side(5'd10, 5'd5, 1'b0, 1'b0, 1'b0, "R4");
      rd(7'h02, 16'h0A05, "R4");
      // R4 R5 R6 all ones, split clear: reserved bits and bit7 dropped
      wr(7'h02, 16'hFFFF);
      rd(7'h02, 16'hBF3F, "R5");
      side(5'd31, 5'd31, 1'b1, 1'b1, 1'b0, "R6");
      // R5 range bit above low data
      wr(7'h02, 16'h2105);
      rd(7'h02, 16'h3F05, "R5");
      side(5'd31, 5'd5, 1'b0, 1'b0, 1'b0, "R5");

      // R6 bit 7 while split clear, then enable split
      wr(7'h02, 16'h0080);
      rd(7'h02, 16'h0000, "R6");
      side(5'd0, 5'd0, 1'b0, 1'b0, 1'b0, "R6");
      wr(7'h76, 16'h0010);
      rd(7'h76, 16'h0010, "R6");
      rd(7'h02, 16'h0000, "R6");
      side(5'd0, 5'd0, 1'b0, 1'b0, 1'b0, "R6");

      // R7 split set
      wr(7'h02, 16'h8000);
      side(5'd0, 5'd0, 1'b1, 1'b0, 1'b0, "R7");
      rd(7'h02, 16'h8000, "R7");
      wr(7'h02, 16'h0080);
      side(5'd0, 5'd0, 1'b0, 1'b1, 1'b0, "R7");
      rd(7'h02, 16'h0080, "R7");
      wr(7'h02, 16'h8080);
      side(5'd0, 5'd0, 1'b1, 1'b1, 1'b0, "R7");

      // R8 routing
      wr(7'h76, 16'h0014);
      side(5'd0, 5'd0, 1'b1, 1'b1, 1'b1, "R8");
      wr(7'h76, 16'hFFFF);
      rd(7'h76, 16'h0014, "R8");
      wr(7'h76, 16'h0010);
      side(5'd0, 5'd0, 1'b1, 1'b1, 1'b0, "R8");

      // R9 serial word
      wr(7'h74, 16'hA5C3);
      rd(7'h74, 16'hA5C3, "R9");

      // R3 soft reset keeps 74h only
      wr(7'h02, 16'h0C0C);
      wr(7'h76, 16'h0014);
      wr(7'h00, 16'h1234);
      side(5'd0, 5'd0, 1'b1, 1'b1, 1'b0, "R3");
      rd(7'h02, 16'h8000, "R3");
      rd(7'h76, 16'h0000, "R3");
      rd(7'h74, 16'hA5C3, "R3");
      rd(7'h00, 16'h0090, "R2");

      // R10 unimplemented and odd addresses
      wr(7'h10, 16'hFFFF);
      rd(7'h10, 16'h0000, "R10");
      rd(7'h7E, 16'h0000, "R10");
      wr(7'h03, 16'h1F1F);
      side(5'd0, 5'd0, 1'b1, 1'b1, 1'b0, "R10");
      rd(7'h02, 16'h8000, "R10");
      rd(7'h01, 16'h0000, "R10");
      rd(7'h75, 16'h0000, "R10");
      wr(7'h02, 16'h0303);
      wr(7'h01, 16'hFFFF);
      rd(7'h02, 16'h0303, "R10");
      side(5'd3, 5'd3, 1'b0, 1'b0, 1'b0, "R10");

      // R11 read and write together, then hold
      rdwr(7'h02, 16'h0707, 16'h0303, "R11");
      side(5'd7, 5'd7, 1'b0, 1'b0, 1'b0, "R11");
      rd(7'h02, 16'h0707, "R11");
      repeat (3) @(negedge clk);
      checks++;
      if (rdata !== 16'h0707) begin
         errors++;
         $display("FAIL R11 hold: actual %h expected %h", rdata, 16'h0707);
      end
      rd(7'h00, 16'h0090, "R11");
      side(5'd7, 5'd7, 1'b0, 1'b0, 1'b0, "R11");

      repeat (2) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R11 pending reads: actual %0d expected 0", exp_q.size());
      end
      done = 1'b1;
      summary();
      $finish;
   end
endmodule